// File: doc/BRIEF.md
# Line Loss-of-Signal Alarm Detector

This block watches a recovered serial receive stream. It takes one data bit on each cycle where the line-clock enable is high. A loss-of-signal alarm rises when the line carries nothing but zeros for a programmable number of pulse periods. The alarm does not clear on the first one that arrives. It clears only when enough ones (a second programmable threshold) land inside one observation window, and that window is the same length as the detection run. The set rule and the clear rule are therefore deliberately different.

Alongside the level alarm there is a sticky interrupt status bit. It latches on the alarm's rising edge and is cleared by a write-one-to-clear strobe. A controller can poll this bit or route it to an interrupt line. Both configuration values are clamped inside the block, so any setting yields a defined behaviour.

Top module: `los_line_monitor`

## Requirements
- R1: With the alarm low, the alarm output goes high in the clock cycle after the enabled sample that completes a run of Tc consecutive enabled zero samples.
- R2: Tc is cfgLen clamped to the range 17 to 4095; cfgLen values below 17 act as 17 and values above 4095 act as 4095.
- R3: With the alarm low, an enabled one sample before the run completes restarts the zero run from the beginning, so Tc further zeros are then needed.
- R4: With the alarm high, the alarm goes low in the cycle after the enabled sample that brings the count of ones in the current observation window up to Mc.
- R5: The observation window spans Tc enabled samples and starts with the first enabled sample after the alarm rises. When a window ends with fewer than Mc ones, the alarm stays high and the ones count starts again from zero in the next window.
- R6: Mc is cfgOnes clamped to the range 1 to Tc; a value of 0 acts as 1, and a value above Tc acts as Tc.
- R7: The interrupt status output goes high in the same cycle the alarm rises and stays high after the alarm falls.
- R8: A clrStrobe cycle clears the interrupt status in the next cycle. If an alarm rise happens in that same cycle, the status stays set.
- R9: Samples with lineEn low have no effect: the alarm, the interrupt status and every run or window count hold their values.
- R10: A synchronous reset brings the alarm and the interrupt status low and restarts all counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| lineEn | input | 1 | Line-clock enable; rxBit is sampled only when high |
| rxBit | input | 1 | Recovered receive data bit |
| cfgLen | input | 13 | Requested detection run and window length in pulse periods |
| cfgOnes | input | 13 | Requested recovery threshold in ones per window |
| clrStrobe | input | 1 | Write-one-to-clear strobe for the interrupt status |
| alarm | output | 1 | Loss-of-signal alarm level |
| alarmIrq | output | 1 | Sticky interrupt status, latched on the alarm's rising edge |

## Verification
The hardest state to reach from the ports is a window boundary during recovery. In that state the ones total stops exactly one short of Mc when the window closes, and the same number of ones must then fail to clear the alarm in the next window. The bench reaches it by raising the alarm and feeding Mc-1 ones. It then pads the window with zeros to exactly Tc samples and repeats the Mc-1 ones, sweeping Mc over several values. A second hard case is a clear strobe that lands on the very cycle of an alarm rise. The bench sets this up by asserting the strobe together with the run-completing zero.

// File: rtl/los_pkg.sv
package los_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic runClr;
    logic runInc;
    logic winClr;
    logic winInc;
  } losCtl_t;

  // compare results from datapath to control
  typedef struct packed {
    logic runDone;
    logic winDone;
    logic onesDone;
  } losSts_t;

  typedef enum logic {
    LOS_CLEAR  = 1'b0,
    LOS_ACTIVE = 1'b1
  } losState_t;

endpackage

// File: rtl/los_cfg_clamp.sv
module los_cfg_clamp #(
  parameter int CFG_W   = 13,
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 17,
  parameter int MAX_LEN = 4095
) (
  input  logic [CFG_W-1:0] cfgLen,
  input  logic [CFG_W-1:0] cfgOnes,
  output logic [LEN_W-1:0] lenEff,
  output logic [LEN_W-1:0] onesEff
);

  localparam logic [CFG_W-1:0] MinC = CFG_W'(MIN_LEN);
  localparam logic [CFG_W-1:0] MaxC = CFG_W'(MAX_LEN);

  logic [CFG_W-1:0] lenWide;

  always_comb begin
    if (cfgLen < MinC)      lenWide = MinC;
    else if (cfgLen > MaxC) lenWide = MaxC;
    else                    lenWide = cfgLen;
    lenEff = lenWide[LEN_W-1:0];
  end

  // threshold is at least one and never beyond the window length
  always_comb begin
    if (cfgOnes == '0)           onesEff = LEN_W'(1);
    else if (cfgOnes > lenWide)  onesEff = lenWide[LEN_W-1:0];
    else                         onesEff = cfgOnes[LEN_W-1:0];
  end

endmodule

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxBit,
  input  losCtl_t          ctl,
  input  logic [LEN_W-1:0] lenEff,
  input  logic [LEN_W-1:0] onesEff,
  output losSts_t          sts
);

  localparam int SUM_W = LEN_W + 1;

  logic [LEN_W-1:0] runCnt;
  logic [LEN_W-1:0] winCnt;
  logic [LEN_W-1:0] onesCnt;
  logic [SUM_W-1:0] runNext;
  logic [SUM_W-1:0] winNext;
  logic [SUM_W-1:0] onesNext;

  always_comb begin
    runNext  = {1'b0, runCnt} + SUM_W'(1);
    winNext  = {1'b0, winCnt} + SUM_W'(1);
    onesNext = {1'b0, onesCnt} + {{LEN_W{1'b0}}, rxBit};
    // >= keeps a live shrink of the length from skipping the end
    sts.runDone  = runNext  >= {1'b0, lenEff};
    sts.winDone  = winNext  >= {1'b0, lenEff};
    sts.onesDone = onesNext >= {1'b0, onesEff};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCnt <= '0;
    end else if (ctl.runClr) begin
      runCnt <= '0;
    end else if (ctl.runInc) begin
      runCnt <= runNext[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.winClr) begin
      winCnt  <= '0;
      onesCnt <= '0;
    end else if (ctl.winInc) begin
      winCnt  <= winNext[LEN_W-1:0];
      onesCnt <= onesNext[LEN_W-1:0];
    end
  end

endmodule

// File: rtl/los_control.sv
module los_control
  import los_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    lineEn,
  input  logic    rxBit,
  input  logic    clrStrobe,
  input  losSts_t sts,
  output losCtl_t ctl,
  output logic    alarm,
  output logic    alarmIrq
);

  losState_t state;
  losState_t stateNext;
  logic      riseEvt;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    riseEvt   = 1'b0;
    if (lineEn) begin
      unique case (state)
        LOS_CLEAR: begin
          if (rxBit) begin
            ctl.runClr = 1'b1;
          end else if (sts.runDone) begin
            stateNext  = LOS_ACTIVE;
            riseEvt    = 1'b1;
            ctl.runClr = 1'b1;
            ctl.winClr = 1'b1;
          end else begin
            ctl.runInc = 1'b1;
          end
        end
        LOS_ACTIVE: begin
          if (sts.onesDone) begin
            stateNext  = LOS_CLEAR;
            ctl.runClr = 1'b1;
            ctl.winClr = 1'b1;
          end else if (sts.winDone) begin
            ctl.winClr = 1'b1;
          end else begin
            ctl.winInc = 1'b1;
          end
        end
        default: stateNext = LOS_CLEAR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LOS_CLEAR;
      alarmIrq <= 1'b0;
    end else begin
      state    <= stateNext;
      alarmIrq <= riseEvt | (alarmIrq & ~clrStrobe);
    end
  end

  assign alarm = (state == LOS_ACTIVE);

endmodule

// File: rtl/los_line_monitor.sv
module los_line_monitor
  import los_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int CFG_W   = LEN_W + 1,
  parameter int MIN_LEN = 17,
  parameter int MAX_LEN = (1 << LEN_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lineEn,
  input  logic             rxBit,
  input  logic [CFG_W-1:0] cfgLen,
  input  logic [CFG_W-1:0] cfgOnes,
  input  logic             clrStrobe,
  output logic             alarm,
  output logic             alarmIrq
);

  logic [LEN_W-1:0] lenEff;
  logic [LEN_W-1:0] onesEff;
  losCtl_t          ctl;
  losSts_t          sts;

  los_cfg_clamp #(
    .CFG_W  (CFG_W),
    .LEN_W  (LEN_W),
    .MIN_LEN(MIN_LEN),
    .MAX_LEN(MAX_LEN)
  ) u_clamp (
    .cfgLen (cfgLen),
    .cfgOnes(cfgOnes),
    .lenEff (lenEff),
    .onesEff(onesEff)
  );

  los_datapath #(
    .LEN_W(LEN_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .rxBit  (rxBit),
    .ctl    (ctl),
    .lenEff (lenEff),
    .onesEff(onesEff),
    .sts    (sts)
  );

  los_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .lineEn   (lineEn),
    .rxBit    (rxBit),
    .clrStrobe(clrStrobe),
    .sts      (sts),
    .ctl      (ctl),
    .alarm    (alarm),
    .alarmIrq (alarmIrq)
  );

endmodule

// File: rtl/los_checker.sv
module los_checker (
  input logic clk,
  input logic rst,
  input logic lineEn,
  input logic rxBit,
  input logic clrStrobe,
  input logic alarm,
  input logic alarmIrq
);

  // R1: alarm can only rise after an enabled zero sample
  p_rise_on_zero_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(lineEn && !rxBit));

  // R4: alarm can only fall after an enabled one sample
  p_fall_on_one_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> $past(lineEn && rxBit));

  // R7: status latches on the rising edge
  p_rise_sets_irq_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> alarmIrq);

  // R7: status is sticky without a strobe
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (alarmIrq && !clrStrobe) |=> alarmIrq);

  // R8: strobe clears unless a rise is possible in that cycle
  p_strobe_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (clrStrobe && !(lineEn && !rxBit && !alarm)) |=> !alarmIrq);

  // R9: a disabled sample leaves the alarm alone
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !lineEn |=> $stable(alarm));

  // R10: reset result
  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!alarm && !alarmIrq));

endmodule

bind los_line_monitor los_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .lineEn   (lineEn),
  .rxBit    (rxBit),
  .clrStrobe(clrStrobe),
  .alarm    (alarm),
  .alarmIrq (alarmIrq)
);

// File: tb/los_line_monitor_tb.sv
`timescale 1ns/1ps
module los_line_monitor_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lineEn = 1'b0;
  logic        rxBit = 1'b0;
  logic        clrStrobe = 1'b0;
  logic [12:0] cfgLen = 13'd17;
  logic [12:0] cfgOnes = 13'd1;
  logic        alarm;
  logic        alarmIrq;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  int mRun = 0, mWin = 0, mOnes = 0;
  bit mAlarm = 0, mIrq = 0;

  always #2.5 clk = ~clk;

  los_line_monitor u_dut (
    .clk(clk), .rst(rst), .lineEn(lineEn), .rxBit(rxBit),
    .cfgLen(cfgLen), .cfgOnes(cfgOnes), .clrStrobe(clrStrobe),
    .alarm(alarm), .alarmIrq(alarmIrq)
  );

  function automatic int effLen();
    int v = int'(cfgLen);
    if (v < 17) v = 17;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  function automatic int effOnes();
    int v = int'(cfgOnes);
    if (v < 1) v = 1;
    if (v > effLen()) v = effLen();
    return v;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic en, input logic b, input logic c);
    bit rise = 0;
    int t = effLen();
    int m = effOnes();
    lineEn = en; rxBit = b; clrStrobe = c;
    if (en) begin
      if (!mAlarm) begin
        if (b) mRun = 0;
        else if (mRun + 1 >= t) begin
          mAlarm = 1; rise = 1; mRun = 0; mWin = 0; mOnes = 0;
        end else mRun++;
      end else begin
        if (mOnes + int'(b) >= m) begin
          mAlarm = 0; mRun = 0; mWin = 0; mOnes = 0;
        end else if (mWin + 1 >= t) begin
          mWin = 0; mOnes = 0;
        end else begin
          mWin++; mOnes += int'(b);
        end
      end
    end
    mIrq = rise | (mIrq & !c);
    @(posedge clk);
    #1;
    chk("R1 R4 R5 R7 model alarm", alarm, mAlarm);
    chk("R7 R8 model irq", alarmIrq, mIrq);
  endtask

  task automatic run(input int n, input logic b);
    for (int i = 0; i < n; i++) step(1'b1, b, 1'b0);
  endtask

  task automatic doReset();
    rst = 1'b1; lineEn = 1'b0; rxBit = 1'b0; clrStrobe = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    mRun = 0; mWin = 0; mOnes = 0; mAlarm = 0; mIrq = 0;
  endtask

  initial begin
    #(2ms);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    doReset();
    chk("R10 reset alarm", alarm, 1'b0);
    chk("R10 reset irq", alarmIrq, 1'b0);

    // R1 R2: detection length sweep
    for (int t = 17; t <= 24; t++) begin
      cfgLen = 13'(t); cfgOnes = 13'd1;
      doReset();
      run(t - 1, 1'b0);
      chk("R1 one zero short", alarm, 1'b0);
      run(1, 1'b0);
      chk("R1 run complete", alarm, 1'b1);
      chk("R7 irq on rise", alarmIrq, 1'b1);
    end

    // R3: a one at every position of the run restarts it
    cfgLen = 13'd18;
    for (int k = 0; k < 18; k++) begin
      doReset();
      run(k, 1'b0);
      run(1, 1'b1);
      run(17, 1'b0);
      chk("R3 restarted run short", alarm, 1'b0);
      run(1, 1'b0);
      chk("R3 restarted run complete", alarm, 1'b1);
    end

    // R2: clamping of the run length
    cfgLen = 13'd3; doReset();
    run(16, 1'b0); chk("R2 low clamp short", alarm, 1'b0);
    run(1, 1'b0);  chk("R2 low clamp hit", alarm, 1'b1);
    cfgLen = 13'd8000; doReset();
    run(4094, 1'b0); chk("R2 high clamp short", alarm, 1'b0);
    run(1, 1'b0);    chk("R2 high clamp hit", alarm, 1'b1);

    // R4 R5: recovery threshold sweep with window boundary
    cfgLen = 13'd20;
    for (int m = 1; m <= 6; m++) begin
      cfgOnes = 13'(m);
      doReset();
      run(20, 1'b0);
      run(m - 1, 1'b1);
      chk("R4 one short of threshold", alarm, 1'b1);
      run(20 - (m - 1), 1'b0);
      chk("R5 window expired", alarm, 1'b1);
      run(m - 1, 1'b1);
      chk("R5 count restarted", alarm, 1'b1);
      run(1, 1'b1);
      chk("R4 threshold reached", alarm, 1'b0);
      chk("R7 irq sticky after fall", alarmIrq, 1'b1);
    end

    // R6: threshold clamps
    cfgLen = 13'd17; cfgOnes = 13'd100; doReset();
    run(17, 1'b0);
    run(16, 1'b1); chk("R6 high clamp short", alarm, 1'b1);
    run(1, 1'b1);  chk("R6 high clamp clears", alarm, 1'b0);
    cfgOnes = 13'd0; doReset();
    run(17, 1'b0);
    run(1, 1'b1);  chk("R6 zero acts as one", alarm, 1'b0);

    // R9: disabled samples are ignored
    cfgOnes = 13'd1; doReset();
    run(16, 1'b0);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0);
    chk("R9 ones ignored while idle", alarm, 1'b0);
    run(1, 1'b0);
    chk("R9 run kept across idle", alarm, 1'b1);
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b0);
    chk("R9 alarm held while idle", alarm, 1'b1);

    // R8: clearing and coincidence
    step(1'b0, 1'b0, 1'b1);
    chk("R8 strobe clears", alarmIrq, 1'b0);
    run(1, 1'b1);
    chk("R8 irq stays clear", alarmIrq, 1'b0);
    run(16, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    chk("R8 rise beats strobe alarm", alarm, 1'b1);
    chk("R8 rise beats strobe irq", alarmIrq, 1'b1);

    // R10: reset while alarmed
    doReset();
    chk("R10 reset clears alarm", alarm, 1'b0);
    chk("R10 reset clears irq", alarmIrq, 1'b0);
    run(16, 1'b0);
    chk("R10 run restarted", alarm, 1'b0);

    // mixed stimulus against the model
    for (int blk = 0; blk < 24; blk++) begin
      cfgLen  = 13'(17 + (blk % 4));
      cfgOnes = 13'(blk % 7);
      for (int i = 0; i < 400; i++) begin
        int r = int'($urandom_range(0, 63));
        step(r < 56, (r % 8) == 0 || (blk % 3 == 0 && r < 20), r == 63);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule